// File: doc/BRIEF.md
# Serial DAC Chain Update Controller

This block is the host-side master for a chain of serially loaded eight-channel voltage converters. A request carries one channel select and one 8-bit output code per device. It is accepted on a valid/ready handshake. The controller packs each pair into a 12-bit word and shifts every word out on a serial clock and data pair. It then pulses a load strobe once, so that all devices in the chain update together.

Every interval is counted in system clock cycles from its own run-time input:
- the serial clock low time,
- the serial clock high time,
- the gap from the last clock fall to the strobe,
- the strobe width,
- the gap after the strobe.

An input of zero acts as one cycle. Data changes only when the serial clock falls. This keeps it stable for the whole low and high phase around each rising edge. After the gap that follows the strobe, a one-cycle completion pulse is issued. The controller then accepts the next request.

The chain length is a parameter. Device slot 0 is wired nearest to the controller. The word for the farthest slot is shifted first, so that each word has travelled to its own device when the strobe arrives.

Top module: `dac_chain_ctrl`

## Requirements
- R1: Word layout: bit Dk of a device word holds the code in D0..D7, with D0 as the code LSB. The channel select sits in D8..D11, with D8 as the select MSB and D11 as the select LSB. Bits leave D11 first and D0 last, each one sampled by a device on a rising edge of `ser_clk`.
- R2: One transfer shifts exactly 12*N_DEV bits: slot N_DEV-1 first, slot 0 last. Slot i takes its select from `req_chan[4i+3:4i]` and its code from `req_code[8i+7:8i]`. Exactly one `ser_load` pulse follows, after the last bit.
- R3: Every high phase of `ser_clk` lasts exactly max(`t_clk_hi`,1) cycles. Every low phase between two rising edges lasts exactly max(`t_clk_lo`,1) cycles. The first low phase lasts the same and starts in the cycle after acceptance.
- R4: `ser_data` changes only in a cycle where `ser_clk` has just fallen. It holds the same value through the low phase before each rising edge and through the high phase after it.
- R5: `ser_load` rises exactly max(`t_ld_setup`,1) cycles after the last fall of `ser_clk`. `ser_clk` stays low from that fall until completion, and the two are never high together.
- R6: `ser_load` stays high for exactly max(`t_ld_width`,1) cycles.
- R7: max(`t_ld_hold`,1) cycles after `ser_load` falls, `done` is high for exactly one cycle. `req_ready` is high in the following cycle.
- R8: `req_ready` is high only while the controller is idle. While it is low, `req_valid` and the request fields are ignored: changes to them after acceptance do not alter the bits shifted.
- R9: Out of reset `req_ready` is high and `ser_clk`, `ser_data`, `ser_load` and `done` are low.
- R10: An interval input of zero behaves exactly as a value of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_chan | input | 4*N_DEV | Channel select per slot, slot i at [4i+3:4i] |
| req_code | input | 8*N_DEV | Output code per slot, slot i at [8i+7:8i] |
| t_clk_lo | input | CNT_W | Serial clock low time, cycles |
| t_clk_hi | input | CNT_W | Serial clock high time, cycles |
| t_ld_setup | input | CNT_W | Last clock fall to strobe rise, cycles |
| t_ld_width | input | CNT_W | Strobe high time, cycles |
| t_ld_hold | input | CNT_W | Strobe fall to completion, cycles |
| ser_clk | output | 1 | Serial clock to the chain |
| ser_data | output | 1 | Serial data to the nearest device |
| ser_load | output | 1 | Load strobe to all devices |
| done | output | 1 | One-cycle completion pulse |

## Verification
Some internal faults show up in the very next cycle at the ports:
- A wrong shift-register load or a wrong bit counter gives a wrong bit at the first affected rising edge of `ser_clk`, or a load strobe after too few or too many edges.
- A timer off by one moves the next edge of `ser_clk` or `ser_load` by a cycle, visible at the end of the phase it governs.
- A sequencer that leaves idle too early or too late shows as `req_ready` high during a transfer, or as a missing `done` one cycle after the hold gap.

The bench therefore measures every phase length and every shifted bit. It does so over all channel values, all 256 codes and a sweep of each interval from zero upward.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  localparam int WORD_W = 12;
  localparam int CODE_W = 8;
  localparam int SEL_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOW   = 3'd1,
    ST_HIGH  = 3'd2,
    ST_LSET  = 3'd3,
    ST_LOAD  = 3'd4,
    ST_LHOLD = 3'd5,
    ST_DONE  = 3'd6
  } dcc_state_t;

  // Word bit k is device bit Dk. Code occupies D0..D7 in natural order;
  // the select is stored reversed so that D11 carries the select LSB.
  function automatic logic [WORD_W-1:0] form_word(input logic [SEL_W-1:0] sel,
                                                  input logic [CODE_W-1:0] code);
    logic [WORD_W-1:0] w;
    w[CODE_W-1:0] = code;
    for (int i = 0; i < SEL_W; i++) begin
      w[CODE_W + i] = sel[SEL_W-1-i];
    end
    return w;
  endfunction

endpackage

// File: rtl/dcc_interval_timer.sv
module dcc_interval_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  // A length of zero or one both give a single-cycle interval.
  function automatic logic [CNT_W-1:0] start_value(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= start_value(len);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/dcc_word_shifter.sv
module dcc_word_shifter
  import dcc_pkg::*;
#(
  parameter int N_DEV = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    adv,
  input  logic [N_DEV*SEL_W-1:0]  sel_flat,
  input  logic [N_DEV*CODE_W-1:0] code_flat,
  output logic                    sdata,
  output logic                    last_bit
);

  localparam int TOT_W = N_DEV * WORD_W;
  localparam int BC_W  = $clog2(TOT_W + 1);

  logic [TOT_W-1:0] packed_words;
  logic [TOT_W-1:0] sr_q;
  logic [BC_W-1:0]  left_q;

  // Slot g lands at bits [12g+11:12g]; the top slot is shifted first.
  for (genvar g = 0; g < N_DEV; g++) begin : g_slot
    assign packed_words[g*WORD_W +: WORD_W] =
      form_word(sel_flat[g*SEL_W +: SEL_W], code_flat[g*CODE_W +: CODE_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      left_q <= '0;
    end else if (load) begin
      sr_q   <= packed_words;
      left_q <= BC_W'(TOT_W);
    end else if (adv) begin
      sr_q   <= {sr_q[TOT_W-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end

  assign sdata    = sr_q[TOT_W-1];
  assign last_bit = (left_q == BC_W'(1));

endmodule

// File: rtl/dcc_sequencer.sv
module dcc_sequencer
  import dcc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tmr_expired,
  input  logic             last_bit,
  input  logic [CNT_W-1:0] t_clk_lo,
  input  logic [CNT_W-1:0] t_clk_hi,
  input  logic [CNT_W-1:0] t_ld_setup,
  input  logic [CNT_W-1:0] t_ld_width,
  input  logic [CNT_W-1:0] t_ld_hold,
  output dcc_state_t       state,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_len,
  output logic             shift_adv
);

  dcc_state_t state_q, state_d;

  always_comb begin
    state_d   = state_q;
    shift_adv = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_LOW;
      ST_LOW:   if (tmr_expired) state_d = ST_HIGH;
      ST_HIGH: begin
        if (tmr_expired) begin
          if (last_bit) begin
            state_d = ST_LSET;
          end else begin
            state_d   = ST_LOW;
            shift_adv = 1'b1;
          end
        end
      end
      ST_LSET:  if (tmr_expired) state_d = ST_LOAD;
      ST_LOAD:  if (tmr_expired) state_d = ST_LHOLD;
      ST_LHOLD: if (tmr_expired) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // Each timed state arms the timer with its own interval on entry.
  always_comb begin
    unique case (state_d)
      ST_LOW:   tmr_len = t_clk_lo;
      ST_HIGH:  tmr_len = t_clk_hi;
      ST_LSET:  tmr_len = t_ld_setup;
      ST_LOAD:  tmr_len = t_ld_width;
      ST_LHOLD: tmr_len = t_ld_hold;
      default:  tmr_len = '0;
    endcase
  end

  assign tmr_load = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/dac_chain_ctrl.sv
module dac_chain_ctrl
  import dcc_pkg::*;
#(
  parameter int N_DEV = 2,
  parameter int CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [N_DEV*SEL_W-1:0]  req_chan,
  input  logic [N_DEV*CODE_W-1:0] req_code,
  input  logic [CNT_W-1:0]        t_clk_lo,
  input  logic [CNT_W-1:0]        t_clk_hi,
  input  logic [CNT_W-1:0]        t_ld_setup,
  input  logic [CNT_W-1:0]        t_ld_width,
  input  logic [CNT_W-1:0]        t_ld_hold,
  output logic                    ser_clk,
  output logic                    ser_data,
  output logic                    ser_load,
  output logic                    done
);

  dcc_state_t       state;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_len;
  logic             tmr_expired;
  logic             shift_adv;
  logic             last_bit;

  // Named events, visible to the bound checker.
  logic ev_accept;
  logic ev_shift;

  assign req_ready = (state == ST_IDLE);
  assign ev_accept = req_valid && req_ready;
  assign ev_shift  = shift_adv;

  dcc_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (ev_accept),
    .tmr_expired (tmr_expired),
    .last_bit    (last_bit),
    .t_clk_lo    (t_clk_lo),
    .t_clk_hi    (t_clk_hi),
    .t_ld_setup  (t_ld_setup),
    .t_ld_width  (t_ld_width),
    .t_ld_hold   (t_ld_hold),
    .state       (state),
    .tmr_load    (tmr_load),
    .tmr_len     (tmr_len),
    .shift_adv   (shift_adv)
  );

  dcc_interval_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .len     (tmr_len),
    .expired (tmr_expired)
  );

  dcc_word_shifter #(.N_DEV(N_DEV)) u_shf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_accept),
    .adv       (ev_shift),
    .sel_flat  (req_chan),
    .code_flat (req_code),
    .sdata     (ser_data),
    .last_bit  (last_bit)
  );

  assign ser_clk  = (state == ST_HIGH);
  assign ser_load = (state == ST_LOAD);
  assign done     = (state == ST_DONE);

endmodule

// File: rtl/dcc_chk.sv
module dcc_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             ev_accept,
  input logic             ser_clk,
  input logic             ser_data,
  input logic             ser_load,
  input logic             done,
  input logic [CNT_W-1:0] t_clk_lo,
  input logic [CNT_W-1:0] t_clk_hi,
  input logic [CNT_W-1:0] t_ld_setup,
  input logic [CNT_W-1:0] t_ld_width
);

  localparam int RUN_W = CNT_W + 1;

  function automatic logic [RUN_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? RUN_W'(1) : RUN_W'(v);
  endfunction

  logic [RUN_W-1:0] hi_run, lo_run, ld_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
      ld_run <= '0;
    end else begin
      hi_run <= ser_clk  ? ((hi_run == '1) ? hi_run : hi_run + 1'b1) : '0;
      lo_run <= !ser_clk ? ((lo_run == '1) ? lo_run : lo_run + 1'b1) : '0;
      ld_run <= ser_load ? ((ld_run == '1) ? ld_run : ld_run + 1'b1) : '0;
    end
  end

  // R3: high phase length exact, low phase at least the programmed time
  a_r3_clk_high_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> hi_run == at_least_one(t_clk_hi));
  a_r3_clk_low_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> lo_run >= at_least_one(t_clk_lo));

  // R4: data steady across each rising edge and through the high phase
  a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_data));

  // R5: strobe after the programmed gap, never with the clock high
  a_r5_load_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_load) |-> lo_run == at_least_one(t_ld_setup));
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_clk && ser_load));

  // R6: strobe width
  a_r6_load_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_load) |-> ld_run == at_least_one(t_ld_width));

  // R7: single-cycle completion followed by readiness
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  // R8: busy once accepted, not ready while shifting or strobing
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !req_ready);
  a_r8_not_ready_active: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk || ser_load) |-> !req_ready);

endmodule

bind dac_chain_ctrl dcc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .ev_accept  (ev_accept),
  .ser_clk    (ser_clk),
  .ser_data   (ser_data),
  .ser_load   (ser_load),
  .done       (done),
  .t_clk_lo   (t_clk_lo),
  .t_clk_hi   (t_clk_hi),
  .t_ld_setup (t_ld_setup),
  .t_ld_width (t_ld_width)
);

// File: tb/dac_chain_ctrl_bench.sv
module dac_chain_ctrl_bench;

  localparam int N   = 2;
  localparam int CW  = 8;
  localparam int TOT = 12 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [4*N-1:0] req_chan = '0;
  logic [8*N-1:0] req_code = '0;
  logic [CW-1:0] t_clk_lo = 8'd1, t_clk_hi = 8'd1, t_ld_setup = 8'd1;
  logic [CW-1:0] t_ld_width = 8'd1, t_ld_hold = 8'd1;
  logic          ser_clk, ser_data, ser_load, done;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  dac_chain_ctrl #(.N_DEV(N), .CNT_W(CW)) u_dac_chain_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_code(req_code),
    .t_clk_lo(t_clk_lo), .t_clk_hi(t_clk_hi), .t_ld_setup(t_ld_setup),
    .t_ld_width(t_ld_width), .t_ld_hold(t_ld_hold),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load), .done(done)
  );

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One complete transfer, measured at the ports on falling clock edges.
  task automatic run_xfer(input logic [4*N-1:0] ch, input logic [8*N-1:0] cd,
                          input int lo, input int hi, input int su,
                          input int wd, input int ho);
    bit bits [TOT];
    int nb = 0, lo_len = 0, hi_len = 0, ld_len = 0, ho_len = 0;
    int bad_lo = 0, bad_hi = 0, bad_setup = 0, bad_hold = 0, bad_chg = 0;
    int bad_ready = 0, overlap = 0, loads = 0, su_got = -1, wd_got = -1;
    int ho_got = -1, nb_at_load = -1, mism = 0;
    bit pc = 1'b0, pd = 1'b0, pl = 1'b0, fell_ld = 1'b0, fin = 1'b0;
    bit ready_after = 1'b0, done_after = 1'b1;
    t_clk_lo = CW'(lo); t_clk_hi = CW'(hi); t_ld_setup = CW'(su);
    t_ld_width = CW'(wd); t_ld_hold = CW'(ho);
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready when idle", int'(req_ready), 1);
    req_valid = 1'b1; req_chan = ch; req_code = cd;
    @(negedge clk);
    // R8: keep offering a different request while busy; it must be ignored
    req_chan = ~ch; req_code = ~cd;
    for (int cyc = 0; cyc < 20000 && !fin; cyc++) begin
      if (cyc > 0) @(negedge clk);
      if (req_ready && !done) bad_ready++;
      if (ser_clk && ser_load) overlap++;
      if (ser_clk) begin
        if (!pc) begin
          if (lo_len != eff(lo)) bad_lo++;
          if (nb < TOT) bits[nb] = ser_data;
          nb++;
          hi_len = 1;
          if (ser_data != pd) bad_setup++;
        end else begin
          hi_len++;
          if (ser_data != pd) bad_hold++;
        end
      end else begin
        if (pc) begin
          if (hi_len != eff(hi)) bad_hi++;
          lo_len = 1;
        end else begin
          lo_len++;
          if (cyc > 0 && ser_data != pd) bad_chg++;
        end
      end
      if (ser_load && !pl) begin
        loads++; su_got = lo_len - 1; nb_at_load = nb; ld_len = 1;
      end else if (ser_load) begin
        ld_len++;
      end else if (pl) begin
        wd_got = ld_len; fell_ld = 1'b1; ho_len = 0;
      end
      if (done) begin
        ho_got = ho_len;
        req_valid = 1'b0;
        fin = 1'b1;
      end else if (fell_ld) begin
        ho_len++;
      end
      pc = ser_clk; pd = ser_data; pl = ser_load;
    end
    @(negedge clk);
    ready_after = req_ready; done_after = done;
    for (int j = 0; j < TOT; j++) begin
      int w = N - 1 - j / 12;
      int p = 11 - j % 12;
      bit e = (p < 8) ? cd[w*8 + p] : ch[w*4 + (11 - p)];
      if (bits[j] != e) mism++;
    end
    chk(fin, "R7 done seen", int'(fin), 1);
    chk(mism == 0, "R1 word bits", mism, 0);
    chk(nb == TOT && nb_at_load == TOT, "R2 bit count before load", nb_at_load, TOT);
    chk(loads == 1, "R2 one load pulse", loads, 1);
    chk(bad_lo == 0 && bad_hi == 0, "R3 clock phase lengths", bad_lo + bad_hi, 0);
    chk(bad_setup + bad_hold + bad_chg == 0, "R4 data stability",
        bad_setup + bad_hold + bad_chg, 0);
    chk(su_got == eff(su) && overlap == 0, "R5 load setup", su_got, eff(su));
    chk(wd_got == eff(wd), "R6 load width", wd_got, eff(wd));
    chk(ho_got == eff(ho), "R7 hold to done", ho_got, eff(ho));
    chk(ready_after && !done_after, "R7 single done then ready",
        int'(ready_after), 1);
    chk(bad_ready == 0, "R8 not ready while busy", bad_ready, 0);
    if (lo == 0 || hi == 0 || su == 0 || wd == 0 || ho == 0)
      chk(bad_lo + bad_hi == 0 && su_got == eff(su) && wd_got == eff(wd) &&
          ho_got == eff(ho), "R10 zero acts as one", bad_lo + bad_hi, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state at the ports
    chk(req_ready == 1'b1, "R9 ready in reset", int'(req_ready), 1);
    chk({ser_clk, ser_data, ser_load, done} == 4'b0, "R9 outputs low in reset",
        int'({ser_clk, ser_data, ser_load, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && {ser_clk, ser_load, done} == 3'b0,
        "R9 idle after reset", int'(req_ready), 1);

    // R1/R2: every channel select value in both slots
    for (int k = 0; k < 16; k++) begin
      run_xfer({4'(15 - k), 4'(k)}, {8'(k * 37 + 5), 8'(k * 17 ^ 8'hA5)},
               1, 1, 1, 1, 1);
    end
    // R1: every code value, slots carrying complementary codes
    for (int c = 0; c < 256; c++) begin
      run_xfer({4'(c % 9), 4'((c + 3) % 9)}, {8'(c), 8'(255 - c)}, 1, 1, 1, 1, 1);
    end
    // R3/R5/R6/R7/R10: sweep each interval from zero upward
    for (int v = 0; v < 5; v++) begin
      run_xfer(8'h21, 16'h5AC3, v, 2, 1, 1, 1);
      run_xfer(8'h43, 16'h0FF0, 2, v, 1, 1, 1);
      run_xfer(8'h65, 16'h8001, 1, 1, v, 2, 1);
      run_xfer(8'h87, 16'h7E18, 1, 1, 2, v, 1);
      run_xfer(8'h18, 16'hC33C, 1, 1, 1, 2, v);
    end
    run_xfer(8'h5A, 16'h9669, 3, 4, 5, 6, 7);
    run_xfer(8'h00, 16'h0000, 0, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule